// File: doc/BRIEF.md
# Codec Mode and Clock Controller

This block sits beside a voice codec's serial port and decides how the codec runs, using nothing but the behaviour of its control pins. It watches the transmit and receive frame syncs, the receive master clock pin (which doubles as a power-down request), and the receive bit clock pin (which doubles as a frequency select). Each pin is classed as either toggling or held at a static level, and from that picture the block settles the operating mode, the master clock to use, the bit clock for receive data and the master clock frequency the codec should expect.

Two timed features sit on top of this. When both frame syncs fall silent, the block waits a fixed number of clock cycles and then powers down. After any power-up, the transmit output is held off until two transmit frame-sync pulses have been seen. All inputs are treated as levels already synchronised to `clk`, which also serves as the reference for the activity window and the power-down timer.

Top module: `codec_mode_ctl`

## Requirements
- R1: During and straight after reset, mode_o is 00 (powered down), and tx_out_en_o and rx_data_en_o are 0.
- R2: A pin counts as toggling when it has shown an edge within the last ACT_WIN cycles of clk; after ACT_WIN cycles without an edge it counts as a static level equal to its current value.
- R3: mode_o encodes 11 full duplex, 01 transmit half channel, 10 receive half channel; both frame syncs toggling gives 11, only the transmit one gives 01, only the receive one gives 10. In 11 and 01, mclk_rx_sel_o is 0 (transmit master clock) whatever the receive master clock pin does.
- R4: In receive half channel, mclk_rx_sel_o is 1 when the receive master clock pin toggles and 0 when it is static.
- R5: Outside full duplex and receive half channel, rx_data_en_o is 0, so receive PCM data is ignored.
- R6: With both frame syncs static, the mode holds for PD_CYCLES cycles after the last frame-sync edge of either direction and then becomes 00.
- R7: The receive master clock pin held static high forces mode 00, taking priority over any frame-sync activity.
- R8: Mode 00 is left only when the power-down pin is low or toggling and at least one frame sync toggles.
- R9: tx_out_en_o is 1 only in modes 11 or 01 and only once two transmit frame-sync rising edges have arrived while the mode was not 00; entering mode 00 clears that count.
- R10: freq_code_o encodes 00 = 1.536 MHz, 01 = 1.536/1.544 MHz, 10 = 2.048 MHz. The select pin toggling or high picks the first set (mu-law 00, A-law 10); held low picks the alternate set (mu-law 10, A-law 01). MU_LAW picks the law.
- R11: rx_bclk_from_tx_o is 1 when the bit clock select pin is static (either level) and 0 when it toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the master clock count base |
| rst_n | input | 1 | Synchronous active-low reset |
| fs_tx_i | input | 1 | Transmit frame sync level |
| fs_rx_i | input | 1 | Receive frame sync level |
| mclk_rx_pd_i | input | 1 | Receive master clock, or power-down request when held high |
| bclk_rx_sel_i | input | 1 | Receive bit clock, or frequency select when static |
| mode_o | output | 2 | Operating mode code |
| mclk_rx_sel_o | output | 1 | 1 selects the receive master clock |
| rx_bclk_from_tx_o | output | 1 | 1 when the transmit bit clock also serves receive data |
| freq_code_o | output | 2 | Expected master clock frequency code |
| rx_data_en_o | output | 1 | Receive PCM data is accepted |
| tx_out_en_o | output | 1 | Transmit data and time-slot outputs may drive |

## Verification
A forced power-down and a counted transmit frame-sync edge can land in the same cycle, since the transmit sync keeps toggling while the power-down pin goes high. The bench keeps both frame syncs running through the whole forced power-down and then releases the pin. It judges the outcome by the mode falling to 00 with the transmit permit gone, and by the permit staying off after release until two fresh transmit pulses have been seen. This shows that power-down won over the edge and that the pulse count was cleared.

// File: rtl/codec_ctl_pkg.sv
// Package: shared mode and frequency encodings for the codec mode controller.
// Assumes: mode bit 0 means the transmit path runs, bit 1 the receive path.
package codec_ctl_pkg;

    typedef enum logic [1:0] {
        MODE_DOWN = 2'b00,
        MODE_TXH  = 2'b01,
        MODE_RXH  = 2'b10,
        MODE_FULL = 2'b11
    } mode_t;

    localparam logic [1:0] FREQ_1536     = 2'b00;
    localparam logic [1:0] FREQ_1536_1544 = 2'b01;
    localparam logic [1:0] FREQ_2048     = 2'b10;

    localparam int PIN_FS_TX = 0;
    localparam int PIN_FS_RX = 1;
    localparam int PIN_MCLK  = 2;
    localparam int PIN_BSEL  = 3;
    localparam int NUM_PINS  = 4;

    // Frequency code for a law and a select-pin set.
    function automatic logic [1:0] freq_of(input logic mu_law, input logic alt_set);
        if (mu_law) return alt_set ? FREQ_2048 : FREQ_1536;
        else        return alt_set ? FREQ_1536_1544 : FREQ_2048;
    endfunction

endpackage

// File: rtl/cmc_activity.sv
// Module: per-pin activity monitor.
// Registers the pin, flags edges and rising edges, and reports the pin as
// toggling while an edge was seen within the last WIN cycles.
// Assumes: the pin is already synchronous to clk.
module cmc_activity #(
    parameter int   WIN     = 32,
    parameter logic RST_LVL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic edge_o,
    output logic rise_o,
    output logic active_o
);
    localparam int CW = $clog2(WIN + 1);

    logic          cur_q, prev_q, act_q;
    logic [CW-1:0] idle_q;

    // Sample the pin and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= RST_LVL;
            prev_q <= RST_LVL;
        end else begin
            cur_q  <= pin_i;
            prev_q <= cur_q;
        end
    end

    assign edge_o  = cur_q ^ prev_q;
    assign rise_o  = cur_q & ~prev_q;
    assign level_o = cur_q;

    // Count quiet cycles and drop the toggling flag when the window runs out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
            act_q  <= 1'b0;
        end else if (edge_o) begin
            idle_q <= '0;
            act_q  <= 1'b1;
        end else if (idle_q == CW'(WIN - 1)) begin
            act_q  <= 1'b0;
        end else begin
            idle_q <= idle_q + 1'b1;
        end
    end

    assign active_o = act_q;
endmodule

// File: rtl/cmc_pd_timer.sv
// Module: silence timer for the frame syncs.
// Restarts on any frame-sync edge and reports expiry after LIMIT quiet cycles.
// Assumes: reset leaves the timer expired so the block starts powered down.
module cmc_pd_timer #(
    parameter int LIMIT = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    output logic expired_o
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    // Count up to the limit, restarting on each frame-sync edge.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= TW'(LIMIT);
        else if (restart_i)            cnt_q <= '0;
        else if (cnt_q != TW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = (cnt_q == TW'(LIMIT));
endmodule

// File: rtl/cmc_tx_gate.sv
// Module: transmit permit after power-up.
// Counts transmit frame-sync rising edges seen while powered up and grants
// the permit from the second one on; power-down clears the count.
// Assumes: down_i reflects the registered mode.
module cmc_tx_gate #(
    parameter int NEED = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic down_i,
    input  logic rise_i,
    output logic permit_o
);
    localparam int GW = $clog2(NEED + 1);

    logic [GW-1:0] seen_q;

    // Saturating pulse count since the last power-up.
    always_ff @(posedge clk) begin
        if (!rst_n)                              seen_q <= '0;
        else if (down_i)                         seen_q <= '0;
        else if (rise_i && seen_q != GW'(NEED))  seen_q <= seen_q + 1'b1;
    end

    assign permit_o = (seen_q == GW'(NEED));
endmodule

// File: rtl/codec_mode_ctl.sv
// Module: codec mode and clock controller (top).
// Classifies four control pins as toggling or static, derives the operating
// mode, clock routing and frequency code, times the silent power-down and
// gates the transmit output after power-up.
// Assumes: all pins are synchronous levels; clk is the master clock count base.
module codec_mode_ctl
    import codec_ctl_pkg::*;
#(
    parameter int ACT_WIN   = 32,
    parameter int PD_CYCLES = 4096,
    parameter bit MU_LAW    = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fs_tx_i,
    input  logic       fs_rx_i,
    input  logic       mclk_rx_pd_i,
    input  logic       bclk_rx_sel_i,
    output logic [1:0] mode_o,
    output logic       mclk_rx_sel_o,
    output logic       rx_bclk_from_tx_o,
    output logic [1:0] freq_code_o,
    output logic       rx_data_en_o,
    output logic       tx_out_en_o
);
    localparam logic [NUM_PINS-1:0] RST_LVLS = 4'b1000;

    logic [NUM_PINS-1:0] pins, lvl, edg, rise, act;
    logic                pd_force, fs_edge, silent, expired, permit;
    mode_t               mode_q, mode_d;

    assign pins = {bclk_rx_sel_i, mclk_rx_pd_i, fs_rx_i, fs_tx_i};

    genvar gi;
    generate
        for (gi = 0; gi < NUM_PINS; gi++) begin : g_mon
            cmc_activity #(.WIN(ACT_WIN), .RST_LVL(RST_LVLS[gi])) u_mon (
                .clk     (clk),
                .rst_n   (rst_n),
                .pin_i   (pins[gi]),
                .level_o (lvl[gi]),
                .edge_o  (edg[gi]),
                .rise_o  (rise[gi]),
                .active_o(act[gi])
            );
        end
    endgenerate

    assign fs_edge  = edg[PIN_FS_TX] | edg[PIN_FS_RX];
    assign pd_force = lvl[PIN_MCLK] & ~act[PIN_MCLK];
    assign silent   = ~act[PIN_FS_TX] & ~act[PIN_FS_RX];

    cmc_pd_timer #(.LIMIT(PD_CYCLES)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart_i(fs_edge),
        .expired_o(expired)
    );

    cmc_tx_gate #(.NEED(2)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .down_i  (mode_q == MODE_DOWN),
        .rise_i  (rise[PIN_FS_TX]),
        .permit_o(permit)
    );

    // Choose the next mode; forced power-down has the highest priority.
    always_comb begin
        mode_d = mode_q;
        if (pd_force)                              mode_d = MODE_DOWN;
        else if (act[PIN_FS_TX] && act[PIN_FS_RX]) mode_d = MODE_FULL;
        else if (act[PIN_FS_TX])                   mode_d = MODE_TXH;
        else if (act[PIN_FS_RX])                   mode_d = MODE_RXH;
        else if (silent && expired)                mode_d = MODE_DOWN;
    end

    // Hold the operating mode.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_DOWN;
        else        mode_q <= mode_d;
    end

    // Drive the clock routing and permit outputs from the held mode.
    always_comb begin
        mode_o            = mode_q;
        mclk_rx_sel_o     = (mode_q == MODE_RXH) && act[PIN_MCLK];
        rx_bclk_from_tx_o = ~act[PIN_BSEL];
        freq_code_o       = freq_of(MU_LAW, ~act[PIN_BSEL] & ~lvl[PIN_BSEL]);
        rx_data_en_o      = mode_q[1];
        tx_out_en_o       = mode_q[0] & permit;
    end
endmodule

// File: rtl/codec_mode_ctl_chk.sv
// Module: property checker for the codec mode controller, bound to the top.
module codec_mode_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_o,
    input logic       mclk_rx_sel_o,
    input logic [1:0] freq_code_o,
    input logic       rx_data_en_o,
    input logic       tx_out_en_o,
    input logic       fs_tx_act,
    input logic       fs_rx_act
);
    // R9
    tx_only_when_tx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_en_o |-> mode_o[0]);

    // R5
    rx_only_when_rx_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_data_en_o |-> (mode_o == 2'b11 || mode_o == 2'b10));

    // R4
    rx_clock_only_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_rx_sel_o |-> (mode_o == 2'b10));

    // R8
    wake_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) ##1 (mode_o != 2'b00) |-> $past(fs_tx_act || fs_rx_act));

    // R9
    permit_not_at_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'b00) |=> !tx_out_en_o);

    // R10
    freq_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        freq_code_o != 2'b11);
endmodule

bind codec_mode_ctl codec_mode_ctl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_o       (mode_o),
    .mclk_rx_sel_o(mclk_rx_sel_o),
    .freq_code_o  (freq_code_o),
    .rx_data_en_o (rx_data_en_o),
    .tx_out_en_o  (tx_out_en_o),
    .fs_tx_act    (act[0]),
    .fs_rx_act    (act[1])
);

// File: tb/test_codec_mode_ctl.sv
module test_codec_mode_ctl;
    localparam int WIN = 32;
    localparam int PDC = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    // pin behaviours: 0 low, 1 high, 2 toggling
    int   b_ftx = 0, b_frx = 0, b_mck = 0, b_bsel = 1;
    logic man_ftx = 1'b0;
    int   cyc = 0;
    logic fs_tx, fs_rx, mclk, bsel;

    logic [1:0] mode, freq, freq_a, mode_a;
    logic       msel, bfromtx, rxen, txen, msel_a, bft_a, rxen_a, txen_a;

    codec_mode_ctl #(.ACT_WIN(WIN), .PD_CYCLES(PDC), .MU_LAW(1'b1)) i_codec_mode_ctl (
        .clk(clk), .rst_n(rst_n), .fs_tx_i(fs_tx), .fs_rx_i(fs_rx),
        .mclk_rx_pd_i(mclk), .bclk_rx_sel_i(bsel), .mode_o(mode),
        .mclk_rx_sel_o(msel), .rx_bclk_from_tx_o(bfromtx), .freq_code_o(freq),
        .rx_data_en_o(rxen), .tx_out_en_o(txen));

    codec_mode_ctl #(.ACT_WIN(WIN), .PD_CYCLES(PDC), .MU_LAW(1'b0)) i_codec_mode_ctl_alaw (
        .clk(clk), .rst_n(rst_n), .fs_tx_i(fs_tx), .fs_rx_i(fs_rx),
        .mclk_rx_pd_i(mclk), .bclk_rx_sel_i(bsel), .mode_o(mode_a),
        .mclk_rx_sel_o(msel_a), .rx_bclk_from_tx_o(bft_a), .freq_code_o(freq_a),
        .rx_data_en_o(rxen_a), .tx_out_en_o(txen_a));

    function automatic logic gen(input int beh, input int c, input bit is_fs);
        if (beh == 2) return is_fs ? ((c % 8) < 2) : c[0];
        return (beh == 1);
    endfunction

    // Pin generator, updated away from the active edge.
    always @(negedge clk) begin
        cyc   <= cyc + 1;
        fs_tx <= gen(b_ftx, cyc, 1'b1) | man_ftx;
        fs_rx <= gen(b_frx, cyc, 1'b1);
        mclk  <= gen(b_mck, cyc, 1'b0);
        bsel  <= gen(b_bsel, cyc, 1'b0);
    end

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_tx();
        man_ftx = 1'b1; wait_cyc(2);
        man_ftx = 1'b0; wait_cyc(8);
    endtask

    // vector: ftx, frx, mck, bsel, mode, msel, bfromtx, freq_mu, freq_a, rxen
    typedef struct packed {
        logic [1:0] ftx, frx, mck, bsel;
        logic [1:0] mode;
        logic       msel, bft;
        logic [1:0] fmu, fa;
        logic       rxen;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 2'd2, 2'd0, 2'd2, 2'b11, 1'b0, 1'b0, 2'b00, 2'b10, 1'b1}, // R3 R11 R10
        '{2'd2, 2'd2, 2'd2, 2'd1, 2'b11, 1'b0, 1'b1, 2'b00, 2'b10, 1'b1}, // R3 R2
        '{2'd2, 2'd0, 2'd2, 2'd0, 2'b01, 1'b0, 1'b1, 2'b10, 2'b01, 1'b0}, // R5 R10
        '{2'd0, 2'd2, 2'd2, 2'd2, 2'b10, 1'b1, 1'b0, 2'b00, 2'b10, 1'b1}, // R4
        '{2'd0, 2'd2, 2'd0, 2'd1, 2'b10, 1'b0, 1'b1, 2'b00, 2'b10, 1'b1}, // R4 R2
        '{2'd2, 2'd2, 2'd1, 2'd2, 2'b00, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0}, // R7
        '{2'd0, 2'd2, 2'd1, 2'd0, 2'b00, 1'b0, 1'b1, 2'b10, 2'b01, 1'b0}, // R7
        '{2'd2, 2'd0, 2'd0, 2'd2, 2'b01, 1'b0, 1'b0, 2'b00, 2'b10, 1'b0}  // R5 R3
    };

    initial begin
        // R1 reset state
        wait_cyc(4);
        check("R1 mode", 8'(mode), 8'h0);
        check("R1 txen", 8'(txen), 8'h0);
        check("R1 rxen", 8'(rxen), 8'h0);
        rst_n = 1'b1;
        wait_cyc(3);
        check("R1 mode after reset", 8'(mode), 8'h0);

        // Table of pin behaviours and settled outputs (R2..R5, R7, R10, R11)
        for (int i = 0; i < NV; i++) begin
            b_ftx = int'(VECS[i].ftx); b_frx = int'(VECS[i].frx);
            b_mck = int'(VECS[i].mck); b_bsel = int'(VECS[i].bsel);
            wait_cyc(120);
            check("R3 mode", 8'(mode), 8'(VECS[i].mode));
            check("R4 msel", 8'(msel), 8'(VECS[i].msel));
            check("R11 bclk", 8'(bfromtx), 8'(VECS[i].bft));
            check("R10 freq mu", 8'(freq), 8'(VECS[i].fmu));
            check("R10 freq a", 8'(freq_a), 8'(VECS[i].fa));
            check("R5 rxen", 8'(rxen), 8'(VECS[i].rxen));
        end

        // R6: silence timeout from transmit half channel
        b_ftx = 0;
        wait_cyc(PDC - 40);
        check("R6 held before timeout", 8'(mode), 8'h1);
        wait_cyc(80);
        check("R6 down after timeout", 8'(mode), 8'h0);
        check("R6 txen down", 8'(txen), 8'h0);

        // R8 R9: wake by transmit pulses, permit after two counted pulses
        b_bsel = 1;
        pulse_tx();
        check("R8 wake on sync", 8'(mode), 8'h1);
        check("R9 off after wake pulse", 8'(txen), 8'h0);
        pulse_tx();
        check("R9 off after one counted", 8'(txen), 8'h0);
        pulse_tx();
        check("R9 on after two counted", 8'(txen), 8'h1);

        // R8: no wake while power-down pin held high
        b_mck = 1;
        wait_cyc(60);
        check("R7 forced down", 8'(mode), 8'h0);
        pulse_tx();
        check("R8 stays down with pin high", 8'(mode), 8'h0);

        // R7 R9: forced power-down while syncs keep running
        b_mck = 0; b_ftx = 2; b_frx = 2;
        wait_cyc(100);
        check("R9 full permit", 8'(txen), 8'h1);
        b_mck = 1;
        wait_cyc(100);
        check("R7 down over sync edges", 8'(mode), 8'h0);
        check("R9 permit gone", 8'(txen), 8'h0);
        b_mck = 0;
        wait_cyc(5);
        check("R8 back to full", 8'(mode), 8'h3);
        check("R9 count cleared", 8'(txen), 8'h0);
        wait_cyc(40);
        check("R9 permit again", 8'(txen), 8'h1);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // Watchdog
    initial begin
        wait_cyc(100000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule